// File: doc/BRIEF.md
# Time-Division Serial Slot Multiplexer

This block joins up to eight byte-wide peripheral channels to a single full-duplex serial line. The line is divided into repeating frames of fixed time slots. Each slot carries one byte, and a programmable table gives each slot an owning destination. A peripheral with more traffic is given more slots in every frame, so the share of the line that each one gets follows its bandwidth. The block makes its own bit clock and frame marker from the system clock.

On the send side, producers push bytes tagged with a 3-bit destination into small per-destination queues. At the start of each slot, the block takes the oldest byte from the queue of that slot's owner and shifts it out. If that queue is empty, it sends the idle code instead. On the receive side, bits from the line are gathered into bytes. Each finished byte that is not the idle code is offered downstream, together with the destination that the table gives for the slot it arrived in. The slot table can only be rewritten while the link is disabled.

Top module: `tdm_slot_mux`

## Requirements
- R1: After reset, `tx_sd`, `fsync`, `sclk`, `rx_valid`, `tx_ovf` and `rx_orun` are all 0. Slot table entry i holds destination i mod N_DEST.
- R2: While `link_en` is high, each bit period lasts BIT_DIV clocks and a frame is N_SLOTS slots of 8 bits. `fsync` is high for exactly the bit period before slot 0, and `sclk` is high in the second half of each bit period. Both are 0 while `link_en` is low.
- R3: In each slot, `tx_sd` carries the head byte of the queue belonging to that slot's owner, most significant bit first, one bit per bit period. That byte is removed from its queue. `tx_sd` is 0 while the link is disabled.
- R4: `rx_sd` is sampled at the end of each bit period of every slot. Eight samples are assembled most significant bit first into `rx_byte`.
- R5: A slot whose owner's queue is empty carries 0x00. A received byte equal to 0x00 is treated as idle and never raises `rx_valid`.
- R6: `rx_dest` equals the table entry of the slot in which the delivered byte was received.
- R7: `rx_valid` is a single-clock pulse, one clock after the clock edge that ends the slot's last bit period, and only when `rx_ready` was high at that edge.
- R8: Each destination has a 4-entry first-in first-out queue. A push to a queue that holds 4 bytes at that edge is dropped, even if a pop happens at the same edge. The drop sets that destination's bit in `tx_ovf`, which stays set until reset.
- R9: If `rx_ready` is low at the edge where a non-idle byte completes, the byte is discarded and `rx_orun` is set and stays set until reset.
- R10: Writes to the slot table (`cfg_we`, slot `cfg_slot`, value `cfg_dest`) take effect only while `link_en` is low. They are ignored while it is high.
- R11: Lowering `link_en` abandons the current frame. When it is raised again, the link starts with the `fsync` bit period and then slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Runs the link when high; holds it idle when low |
| cfg_we | input | 1 | Slot table write strobe |
| cfg_slot | input | 4 | Slot index to write |
| cfg_dest | input | 3 | Destination that will own the slot |
| tx_push | input | 1 | Push a byte into a send queue |
| tx_dest | input | 3 | Destination queue for the push |
| tx_byte | input | 8 | Byte to push |
| tx_ovf | output | 8 | Sticky per-destination queue overflow flags |
| rx_sd | input | 1 | Serial receive data |
| rx_ready | input | 1 | Downstream can take a byte |
| rx_valid | output | 1 | Received byte presented |
| rx_byte | output | 8 | Received byte |
| rx_dest | output | 3 | Destination mapped from the receive slot |
| rx_orun | output | 1 | Sticky receive overrun flag |
| tx_sd | output | 1 | Serial transmit data |
| fsync | output | 1 | Frame marker, one bit period wide |
| sclk | output | 1 | Generated bit clock |

## Verification
Each bit period ends on the edge at which the divider reaches its last count. At that edge `tx_sd` moves to the next bit, a queue head is popped when a slot starts, and the receive shifter takes a sample. `rx_valid`, `rx_byte` and `rx_dest` appear one clock after the edge that ends a slot's last bit, an overflow flag rises one clock after the rejected push, and `fsync` and `sclk` follow the counters from that same edge onward. The bench loops `tx_sd` back into `rx_sd`. A behavioural model in the bench is advanced at the same rising edge as the design and compared at the following falling edge, so every result is checked in the exact clock in which it falls due.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } bit_order_e;

   function automatic int unsigned width_of(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tdm_clkgen.sv
module tdm_clkgen #(
   parameter int unsigned BIT_DIV = 2,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_SLOTS = 16,
   localparam int unsigned DIV_W  = tdm_pkg::width_of(BIT_DIV),
   localparam int unsigned BIT_W  = tdm_pkg::width_of(DATA_W),
   localparam int unsigned SLOT_W = tdm_pkg::width_of(N_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   output logic              tick,
   output logic              live,
   output logic              last_bit,
   output logic [SLOT_W-1:0] slot_idx,
   output logic [SLOT_W-1:0] next_slot,
   output logic              fsync,
   output logic              sclk
);
   localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(BIT_DIV - 1);
   localparam logic [DIV_W-1:0]  DIV_HALF  = DIV_W'(BIT_DIV / 2);
   localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_W - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SLOTS - 1);

   logic [DIV_W-1:0]  div_q;
   logic [BIT_W-1:0]  bit_q;
   logic [SLOT_W-1:0] slot_q;
   logic              live_q;

   assign tick      = en && (div_q == DIV_LAST);
   assign last_bit  = (bit_q == BIT_LAST);
   assign next_slot = (slot_q == SLOT_LAST) ? '0 : slot_q + SLOT_W'(1);
   assign fsync     = en && last_bit && (slot_q == SLOT_LAST);
   assign sclk      = en && (div_q >= DIV_HALF);
   assign slot_idx  = slot_q;
   assign live      = live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         bit_q  <= BIT_LAST;
         slot_q <= SLOT_LAST;
         live_q <= 1'b0;
      end else if (!en) begin
         div_q  <= '0;
         bit_q  <= BIT_LAST;
         slot_q <= SLOT_LAST;
         live_q <= 1'b0;
      end else if (tick) begin
         div_q  <= '0;
         live_q <= 1'b1;
         if (last_bit) begin
            bit_q  <= '0;
            slot_q <= next_slot;
         end else begin
            bit_q  <= bit_q + BIT_W'(1);
         end
      end else begin
         div_q <= div_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/tdm_txq.sv
module tdm_txq #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned PTR_W = tdm_pkg::width_of(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              ovf
);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_q, wr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              push_ok, pop_ok;

   assign push_ok = push && (cnt_q != CNT_W'(DEPTH));
   assign pop_ok  = pop && (cnt_q != '0);
   assign empty   = (cnt_q == '0);
   assign head    = mem[rd_q];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
         ovf   <= 1'b0;
      end else begin
         if (push_ok) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + PTR_W'(1);
         if (pop_ok)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + PTR_W'(1);
         cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
         if (push && !push_ok) ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_DEST  = 8,
   parameter int unsigned Q_DEPTH = 4,
   parameter tdm_pkg::bit_order_e ORDER = tdm_pkg::ORDER_MSB_FIRST,
   localparam int unsigned ADDR_W = tdm_pkg::width_of(N_DEST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_dest,
   input  logic [DATA_W-1:0] push_data,
   input  logic              tick,
   input  logic              last_bit,
   input  logic [ADDR_W-1:0] owner_next,
   output logic              tx_sd,
   output logic [N_DEST-1:0] ovf
);
   logic [DATA_W-1:0] head [N_DEST];
   logic [N_DEST-1:0] empty;
   logic [DATA_W-1:0] load_byte;
   logic [DATA_W-1:0] sh_q, sh_next;
   logic              slot_start;

   assign slot_start = tick && last_bit;

   for (genvar g = 0; g < N_DEST; g++) begin : g_queue
      tdm_txq #(.DATA_W(DATA_W), .DEPTH(Q_DEPTH)) i_txq (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (push && (push_dest == ADDR_W'(g))),
         .push_data (push_data),
         .pop       (slot_start && (owner_next == ADDR_W'(g))),
         .head      (head[g]),
         .empty     (empty[g]),
         .ovf       (ovf[g])
      );
   end

   always_comb begin
      load_byte = '0;
      for (int g = 0; g < N_DEST; g++) begin
         if (owner_next == ADDR_W'(g) && !empty[g]) load_byte = head[g];
      end
   end

   if (ORDER == tdm_pkg::ORDER_MSB_FIRST) begin : g_msb
      assign tx_sd   = sh_q[DATA_W-1];
      assign sh_next = {sh_q[DATA_W-2:0], 1'b0};
   end else begin : g_lsb
      assign tx_sd   = sh_q[0];
      assign sh_next = {1'b0, sh_q[DATA_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sh_q <= '0;
      else if (!en)        sh_q <= '0;
      else if (slot_start) sh_q <= load_byte;
      else if (tick)       sh_q <= sh_next;
   end
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter tdm_pkg::bit_order_e ORDER = tdm_pkg::ORDER_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              live,
   input  logic              last_bit,
   input  logic              rx_sd,
   input  logic [ADDR_W-1:0] cur_dest,
   input  logic              rx_ready,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_byte,
   output logic [ADDR_W-1:0] rx_dest,
   output logic              rx_orun
);
   logic [DATA_W-2:0] sh_q;
   logic [DATA_W-1:0] assembled;
   logic              sample, done, deliver;

   if (ORDER == tdm_pkg::ORDER_MSB_FIRST) begin : g_msb
      assign assembled = {sh_q, rx_sd};
   end else begin : g_lsb
      assign assembled = {rx_sd, sh_q};
   end

   assign sample  = tick && live;
   assign done    = sample && last_bit && (assembled != '0);
   assign deliver = done && rx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
         rx_dest  <= '0;
         rx_orun  <= 1'b0;
      end else begin
         rx_valid <= deliver;
         if (sample) begin
            if (ORDER == tdm_pkg::ORDER_MSB_FIRST) sh_q <= assembled[DATA_W-2:0];
            else                                   sh_q <= assembled[DATA_W-1:1];
         end
         if (deliver) begin
            rx_byte <= assembled;
            rx_dest <= cur_dest;
         end
         if (done && !rx_ready) rx_orun <= 1'b1;
      end
   end
endmodule

// File: rtl/tdm_slot_mux.sv
module tdm_slot_mux #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_SLOTS = 16,
   parameter int unsigned N_DEST  = 8,
   parameter int unsigned Q_DEPTH = 4,
   parameter int unsigned BIT_DIV = 2,
   parameter tdm_pkg::bit_order_e ORDER = tdm_pkg::ORDER_MSB_FIRST,
   localparam int unsigned ADDR_W = tdm_pkg::width_of(N_DEST),
   localparam int unsigned SLOT_W = tdm_pkg::width_of(N_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_en,
   input  logic              cfg_we,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [ADDR_W-1:0] cfg_dest,
   input  logic              tx_push,
   input  logic [ADDR_W-1:0] tx_dest,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [N_DEST-1:0] tx_ovf,
   input  logic              rx_sd,
   input  logic              rx_ready,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_byte,
   output logic [ADDR_W-1:0] rx_dest,
   output logic              rx_orun,
   output logic              tx_sd,
   output logic              fsync,
   output logic              sclk
);
   if (BIT_DIV < 2) begin : g_bad_div
      $error("BIT_DIV must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (N_SLOTS < 2 || Q_DEPTH < 1 || N_DEST < 1) begin : g_bad_size
      $error("N_SLOTS, Q_DEPTH and N_DEST out of range");
   end

   logic [ADDR_W-1:0]         slot_map [N_SLOTS];
   logic [N_SLOTS*ADDR_W-1:0] map_flat;
   logic                      tick, live, last_bit;
   logic [SLOT_W-1:0]         slot_idx, next_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_SLOTS; i++) slot_map[i] <= ADDR_W'(i % N_DEST);
      end else if (cfg_we && !link_en) begin
         slot_map[cfg_slot] <= cfg_dest;
      end
   end

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_flat
      assign map_flat[s*ADDR_W +: ADDR_W] = slot_map[s];
   end

   tdm_clkgen #(.BIT_DIV(BIT_DIV), .DATA_W(DATA_W), .N_SLOTS(N_SLOTS)) i_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (link_en),
      .tick      (tick),
      .live      (live),
      .last_bit  (last_bit),
      .slot_idx  (slot_idx),
      .next_slot (next_slot),
      .fsync     (fsync),
      .sclk      (sclk)
   );

   tdm_tx #(.DATA_W(DATA_W), .N_DEST(N_DEST), .Q_DEPTH(Q_DEPTH), .ORDER(ORDER)) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (link_en),
      .push       (tx_push),
      .push_dest  (tx_dest),
      .push_data  (tx_byte),
      .tick       (tick),
      .last_bit   (last_bit),
      .owner_next (slot_map[next_slot]),
      .tx_sd      (tx_sd),
      .ovf        (tx_ovf)
   );

   tdm_rx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ORDER(ORDER)) i_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .live     (live),
      .last_bit (last_bit),
      .rx_sd    (rx_sd),
      .cur_dest (slot_map[slot_idx]),
      .rx_ready (rx_ready),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .rx_dest  (rx_dest),
      .rx_orun  (rx_orun)
   );
endmodule

// File: rtl/tdm_slot_mux_chk.sv
module tdm_slot_mux_chk #(
   parameter int unsigned N_DEST = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MAP_W  = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_en,
   input logic              fsync,
   input logic              sclk,
   input logic              tx_sd,
   input logic [N_DEST-1:0] tx_ovf,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic [DATA_W-1:0] rx_byte,
   input logic              rx_orun,
   input logic [MAP_W-1:0]  map_flat
);
   AST_FSYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n) !link_en |-> !fsync && !sclk); // R2
   AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $past(!link_en) |-> !tx_sd); // R3
   AST_NO_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> rx_byte != '0); // R5
   AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R7
   AST_RX_READY_SEEN: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> $past(rx_ready)); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ~|($past(tx_ovf) & ~tx_ovf)); // R8
   AST_ORUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(rx_orun) |-> rx_orun); // R9
   AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) link_en && $past(link_en) |-> $stable(map_flat)); // R10
endmodule

bind tdm_slot_mux tdm_slot_mux_chk #(
   .N_DEST (N_DEST),
   .DATA_W (DATA_W),
   .MAP_W  (N_SLOTS * ADDR_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .link_en  (link_en),
   .fsync    (fsync),
   .sclk     (sclk),
   .tx_sd    (tx_sd),
   .tx_ovf   (tx_ovf),
   .rx_valid (rx_valid),
   .rx_ready (rx_ready),
   .rx_byte  (rx_byte),
   .rx_orun  (rx_orun),
   .map_flat (map_flat)
);

// File: tb/test_tdm_slot_mux.sv
module test_tdm_slot_mux;
   localparam int DIV = 2;
   localparam int NS  = 16;
   localparam int ND  = 8;
   localparam int QD  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       link_en = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_slot = '0;
   logic [2:0] cfg_dest = '0;
   logic       tx_push = 1'b0;
   logic [2:0] tx_dest = '0;
   logic [7:0] tx_byte = '0;
   logic       rx_ready = 1'b1;
   logic [7:0] tx_ovf;
   logic       rx_valid, rx_orun, tx_sd, fsync, sclk;
   logic [7:0] rx_byte;
   logic [2:0] rx_dest;

   always #2 clk = ~clk;

   tdm_slot_mux i_tdm_slot_mux (
      .clk(clk), .rst_n(rst_n), .link_en(link_en),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_dest(cfg_dest),
      .tx_push(tx_push), .tx_dest(tx_dest), .tx_byte(tx_byte), .tx_ovf(tx_ovf),
      .rx_sd(tx_sd), .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_dest(rx_dest), .rx_orun(rx_orun), .tx_sd(tx_sd), .fsync(fsync), .sclk(sclk)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference
   int m_div, m_bit, m_slot, m_txsh, m_rxsh, m_rd, m_ra, lb, b, ns, own;
   int m_map [NS];
   int q [ND][$];
   bit m_live, m_rv, m_orun, tk, push_ok;
   bit [ND-1:0] m_ovf;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; m_bit = 7; m_slot = NS - 1; m_live = 0; m_txsh = 0; m_rxsh = 0;
         m_rv = 0; m_rd = 0; m_ra = 0; m_orun = 0; m_ovf = '0;
         for (int i = 0; i < NS; i++) m_map[i] = i % ND;
         for (int d = 0; d < ND; d++) q[d].delete();
      end else begin
         tk = link_en && (m_div == DIV - 1);
         lb = (m_txsh >> 7) & 1;
         push_ok = tx_push && (q[tx_dest].size() < QD);
         if (tx_push && !push_ok) m_ovf[tx_dest] = 1'b1;
         m_rv = 0;
         if (tk && m_live) begin
            b = ((m_rxsh << 1) | lb) & 255;
            if (m_bit == 7 && b != 0) begin
               if (rx_ready) begin m_rv = 1; m_rd = b; m_ra = m_map[m_slot]; end
               else m_orun = 1;
            end
            m_rxsh = b;
         end
         if (cfg_we && !link_en) m_map[cfg_slot] = cfg_dest;
         if (!link_en) begin
            m_div = 0; m_bit = 7; m_slot = NS - 1; m_live = 0; m_txsh = 0;
         end else if (tk) begin
            if (m_bit == 7) begin
               ns = (m_slot + 1) % NS;
               own = m_map[ns];
               if (q[own].size() > 0) m_txsh = q[own].pop_front();
               else m_txsh = 0;
               m_bit = 0; m_slot = ns;
            end else begin
               m_txsh = (m_txsh << 1) & 255;
               m_bit++;
            end
            m_div = 0; m_live = 1;
         end else begin
            m_div++;
         end
         if (push_ok) q[tx_dest].push_back(int'(tx_byte));
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(tx_sd == m_txsh[7], "R3 R5 tx_sd", int'(tx_sd), m_txsh[7]);
         check(fsync == (link_en && m_bit == 7 && m_slot == NS - 1), "R2 R11 fsync",
               int'(fsync), int'(link_en && m_bit == 7 && m_slot == NS - 1));
         check(sclk == (link_en && m_div >= DIV / 2), "R2 sclk", int'(sclk), int'(link_en && m_div >= DIV / 2));
         check(rx_valid == m_rv, "R5 R7 rx_valid", int'(rx_valid), int'(m_rv));
         if (m_rv) begin
            check(int'(rx_byte) == m_rd, "R4 rx_byte", int'(rx_byte), m_rd);
            check(int'(rx_dest) == m_ra, "R1 R6 R10 rx_dest", int'(rx_dest), m_ra);
         end
         check(tx_ovf == m_ovf, "R8 tx_ovf", int'(tx_ovf), int'(m_ovf));
         check(rx_orun == m_orun, "R9 rx_orun", int'(rx_orun), int'(m_orun));
      end
   end

   task automatic step(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic push(int d, int v);
      tx_push = 1'b1; tx_dest = 3'(d); tx_byte = 8'(v);
      step(1);
      tx_push = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      step(4);
      @(negedge clk);
      check(tx_sd == 1'b0 && fsync == 1'b0 && sclk == 1'b0, "R1 line outputs", int'({tx_sd, fsync, sclk}), 0);
      check(rx_valid == 1'b0 && rx_orun == 1'b0, "R1 rx flags", int'({rx_valid, rx_orun}), 0);
      check(tx_ovf == '0, "R1 tx_ovf", int'(tx_ovf), 0);
      rst_n = 1'b1;
      step(2);

      // default table, one byte per destination
      for (int d = 0; d < ND; d++) push(d, 8'h11 * (d + 1) + 1);
      link_en = 1'b1;
      step(2 * NS * 8 * DIV);
      link_en = 1'b0;
      step(3);

      // bandwidth-weighted table, destination 7 owns no slot
      for (int s = 0; s < NS; s++) begin
         cfg_we = 1'b1; cfg_slot = 4'(s);
         cfg_dest = (s < 6) ? 3'd0 : (s < 10) ? 3'd1 : (s < 12) ? 3'd2 : 3'(s - 9);
         step(1);
      end
      cfg_we = 1'b0;
      link_en = 1'b1;

      // mixed traffic, table writes while running, occasional not-ready
      for (int c = 0; c < 8 * NS * 8 * DIV; c++) begin
         tx_push  = ($urandom_range(0, 5) == 0);
         tx_dest  = 3'($urandom_range(0, 7));
         tx_byte  = ($urandom_range(0, 9) == 0) ? 8'h00 : 8'($urandom_range(1, 255));
         rx_ready = ($urandom_range(0, 15) != 0);
         cfg_we   = (c < 4);
         cfg_slot = 4'(c);
         cfg_dest = 3'd7;
         step(1);
      end
      tx_push = 1'b0; cfg_we = 1'b0; rx_ready = 1'b1;

      // burst into one queue
      for (int k = 0; k < 6; k++) push(2, 8'hA0 + k);
      step(NS * 8 * DIV);

      // a full frame with downstream not ready
      for (int d = 0; d < 6; d++) push(d, 8'h5A);
      rx_ready = 1'b0;
      step(NS * 8 * DIV);
      rx_ready = 1'b1;
      @(negedge clk);
      check(rx_orun == 1'b1, "R9 overrun latched", int'(rx_orun), 1);
      step(1);

      // abandon mid-frame and restart
      for (int d = 0; d < 6; d++) push(d, 8'hC3 + d);
      step(37);
      link_en = 1'b0;
      step(5);
      for (int d = 0; d < 6; d++) push(d, 8'h3C + d);
      link_en = 1'b1;
      step(3 * NS * 8 * DIV);

      finished = 1;
      summary();
      $finish;
   end
endmodule